// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B, through a pair of one-way paths. Each path has its own storage register, its own capture clock input, a select that picks either the live value of the far bus or the stored copy, and an output enable. The A-to-B enable is active high and the B-to-A enable is active low. When both are inactive the block leaves both buses undriven and only listens.

The pads are modelled as three signals per bus: an incoming value, an outgoing value and a drive flag. The two capture clock inputs are plain levels. A single system clock samples them and detects rising edges. When both directions drive with live data, each bus would feed the other in a loop. In that case the block drives both buses from per-bus hold registers, so each bus keeps its last value.

Top module: `regbus_xcvr`

## Requirements
- R1: A rising level on `ab_clk_i` stores the effective A bus value into the A register, and a rising level on `ba_clk_i` stores the effective B bus value into the B register, whatever the selects and enables are. The stored value is visible from the next system cycle. A capture input that stays high stores nothing further.
- R2: `b_oe_o` is 1 exactly when `ab_oe_i` is 1, and `a_oe_o` is 1 exactly when `ba_oe_n_i` is 0. With `ab_oe_i`=0 and `ba_oe_n_i`=1, neither bus is driven.
- R3: A driven bus carries the other side's live bus value when its select is 0 (`ab_sel_i` for bus B, `ba_sel_i` for bus A), and the opposite register's content when its select is 1.
- R4: The effective value of a bus is its pad input when the bus is undriven, and the block's own output when it is driven. A capture from a driven bus therefore takes the driven value.
- R5: With both directions enabled and both selects at 0, both buses hold the value they had in the cycle before this mode was entered. They ignore their pad inputs until the mode is left.
- R6: With both directions enabled and both selects at 1, bus B carries the A register and bus A carries the B register at the same time. Simultaneous capture edges in this mode exchange the two register contents.
- R7: With `ab_oe_i`=1, `ba_oe_n_i`=1 and `ab_sel_i`=0, simultaneous capture edges load the A pad value into both registers. With `ab_oe_i`=0, `ba_oe_n_i`=0 and `ba_sel_i`=0, they load the B pad value into both registers.
- R8: A synchronous active-low `rst_n` clears both registers and both bus-hold values to zero, and clears the edge history to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples everything |
| rst_n | input | 1 | Synchronous active-low reset |
| ab_clk_i | input | 1 | Capture level for the A register |
| ba_clk_i | input | 1 | Capture level for the B register |
| ab_oe_i | input | 1 | Drive bus B (active high) |
| ba_oe_n_i | input | 1 | Drive bus A (active low) |
| ab_sel_i | input | 1 | Bus B source: 0 live A, 1 A register |
| ba_sel_i | input | 1 | Bus A source: 0 live B, 1 B register |
| a_in_i | input | WIDTH | Value seen at the A pads |
| a_out_o | output | WIDTH | Value the block puts on bus A |
| a_oe_o | output | 1 | Drive flag for bus A |
| b_in_i | input | WIDTH | Value seen at the B pads |
| b_out_o | output | WIDTH | Value the block puts on bus B |
| b_oe_o | output | 1 | Drive flag for bus B |

## Verification
The bench builds the block with WIDTH=4. At that width every pad value can be swept, and every pad value can be stored in every capture mode. The live-routing sweep steps through all sixteen enable and select combinations except the looped one, with all sixteen A values, and checks both outputs and both drive flags against values worked out from the routing rules. The looped hold, the register exchange, the double-load modes, a capture input held high and a mid-run reset are each run with chosen values.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

   typedef struct packed {
      logic ab_oe;
      logic ba_oe_n;
      logic ab_sel;
      logic ba_sel;
   } xc_ctl_t;

   localparam int SIDE_A = 0;
   localparam int SIDE_B = 1;
   localparam int N_SIDE = 2;

   // both directions driving live data: buses would feed each other
   function automatic logic is_loop(input xc_ctl_t c);
      return c.ab_oe & ~c.ba_oe_n & ~c.ab_sel & ~c.ba_sel;
   endfunction

endpackage

// File: rtl/regbus_edge.sv
module regbus_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);
   logic lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/regbus_store.sv
module regbus_store #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      q_o <= '0;
      else if (load_i) q_o <= d_i;
   end
endmodule

// File: rtl/regbus_route.sv
module regbus_route
   import regbus_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  xc_ctl_t          ctl_i,
   input  logic [WIDTH-1:0] a_in_i,
   input  logic [WIDTH-1:0] b_in_i,
   input  logic [WIDTH-1:0] a_reg_i,
   input  logic [WIDTH-1:0] b_reg_i,
   input  logic [WIDTH-1:0] a_hold_i,
   input  logic [WIDTH-1:0] b_hold_i,
   output logic [WIDTH-1:0] a_bus_o,
   output logic [WIDTH-1:0] b_bus_o,
   output logic             a_drv_o,
   output logic             b_drv_o
);
   // Each effective bus value is computed straight from inputs and
   // state, never from the other bus, so no combinational loop exists.
   always_comb begin
      a_drv_o = ~ctl_i.ba_oe_n;
      b_drv_o = ctl_i.ab_oe;
      if (is_loop(ctl_i)) begin
         a_bus_o = a_hold_i;
         b_bus_o = b_hold_i;
      end else begin
         if (!b_drv_o)        b_bus_o = b_in_i;
         else if (ctl_i.ab_sel) b_bus_o = a_reg_i;
         else if (a_drv_o)    b_bus_o = b_reg_i;  // A bus carries stored B
         else                 b_bus_o = a_in_i;

         if (!a_drv_o)        a_bus_o = a_in_i;
         else if (ctl_i.ba_sel) a_bus_o = b_reg_i;
         else if (b_drv_o)    a_bus_o = a_reg_i;  // B bus carries stored A
         else                 a_bus_o = b_in_i;
      end
   end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
   import regbus_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ab_clk_i,
   input  logic             ba_clk_i,
   input  logic             ab_oe_i,
   input  logic             ba_oe_n_i,
   input  logic             ab_sel_i,
   input  logic             ba_sel_i,
   input  logic [WIDTH-1:0] a_in_i,
   output logic [WIDTH-1:0] a_out_o,
   output logic             a_oe_o,
   input  logic [WIDTH-1:0] b_in_i,
   output logic [WIDTH-1:0] b_out_o,
   output logic             b_oe_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("regbus_xcvr: WIDTH must be at least 1");
   end

   xc_ctl_t ctl;
   assign ctl = '{ab_oe: ab_oe_i, ba_oe_n: ba_oe_n_i,
                  ab_sel: ab_sel_i, ba_sel: ba_sel_i};

   logic [N_SIDE-1:0]            cap_lvl, cap_rise;
   logic [N_SIDE-1:0][WIDTH-1:0] bus_v, reg_q, hold_q;

   assign cap_lvl[SIDE_A] = ab_clk_i;
   assign cap_lvl[SIDE_B] = ba_clk_i;

   for (genvar s = 0; s < N_SIDE; s++) begin : g_side
      regbus_edge u_edge (
         .clk   (clk),
         .rst_n (rst_n),
         .lvl_i (cap_lvl[s]),
         .rise_o(cap_rise[s])
      );
      regbus_store #(.WIDTH(WIDTH)) u_data (
         .clk   (clk),
         .rst_n (rst_n),
         .load_i(cap_rise[s]),
         .d_i   (bus_v[s]),
         .q_o   (reg_q[s])
      );
      regbus_store #(.WIDTH(WIDTH)) u_hold (
         .clk   (clk),
         .rst_n (rst_n),
         .load_i(1'b1),
         .d_i   (bus_v[s]),
         .q_o   (hold_q[s])
      );
   end

   regbus_route #(.WIDTH(WIDTH)) u_route (
      .ctl_i   (ctl),
      .a_in_i  (a_in_i),
      .b_in_i  (b_in_i),
      .a_reg_i (reg_q[SIDE_A]),
      .b_reg_i (reg_q[SIDE_B]),
      .a_hold_i(hold_q[SIDE_A]),
      .b_hold_i(hold_q[SIDE_B]),
      .a_bus_o (bus_v[SIDE_A]),
      .b_bus_o (bus_v[SIDE_B]),
      .a_drv_o (a_oe_o),
      .b_drv_o (b_oe_o)
   );

   assign a_out_o = bus_v[SIDE_A];
   assign b_out_o = bus_v[SIDE_B];
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ab_clk_i,
   input logic             ba_clk_i,
   input logic             ab_oe_i,
   input logic             ba_oe_n_i,
   input logic             ab_sel_i,
   input logic             ba_sel_i,
   input logic [WIDTH-1:0] a_in_i,
   input logic [WIDTH-1:0] a_out_o,
   input logic             a_oe_o,
   input logic [WIDTH-1:0] b_in_i,
   input logic [WIDTH-1:0] b_out_o,
   input logic             b_oe_o
);
   logic ab_prev, ba_prev;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ab_prev <= 1'b0;
         ba_prev <= 1'b0;
      end else begin
         ab_prev <= ab_clk_i;
         ba_prev <= ba_clk_i;
      end
   end

   logic ab_rise, any_rise, loop_m, cross_m;
   assign ab_rise  = ab_clk_i & ~ab_prev;
   assign any_rise = ab_rise | (ba_clk_i & ~ba_prev);
   assign loop_m   = ab_oe_i & ~ba_oe_n_i & ~ab_sel_i & ~ba_sel_i;
   assign cross_m  = ab_oe_i & ~ba_oe_n_i & ab_sel_i & ba_sel_i;

   AST_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_oe_i && ba_oe_n_i) |-> (!a_oe_o && !b_oe_o)); // R2
   AST_LIVE_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_oe_i && !ab_sel_i && ba_oe_n_i) |-> (b_out_o == a_in_i)); // R3
   AST_LIVE_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
      (!ba_oe_n_i && !ba_sel_i && !ab_oe_i) |-> (a_out_o == b_in_i)); // R3
   AST_CAPTURE_A: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_rise && ba_oe_n_i) |=> ((ab_oe_i && ab_sel_i) -> (b_out_o == $past(a_in_i)))); // R1
   AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_m && $past(loop_m) && $past(rst_n)) |-> ($stable(a_out_o) && $stable(b_out_o))); // R5
   AST_CROSS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cross_m && $past(cross_m) && !$past(any_rise) && $past(rst_n))
      |-> ($stable(a_out_o) && $stable(b_out_o))); // R6
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .ab_clk_i(ab_clk_i), .ba_clk_i(ba_clk_i),
   .ab_oe_i(ab_oe_i), .ba_oe_n_i(ba_oe_n_i), .ab_sel_i(ab_sel_i),
   .ba_sel_i(ba_sel_i), .a_in_i(a_in_i), .a_out_o(a_out_o), .a_oe_o(a_oe_o),
   .b_in_i(b_in_i), .b_out_o(b_out_o), .b_oe_o(b_oe_o)
);

// File: tb/regbus_xcvr_tb.sv
module regbus_xcvr_tb_top;
   localparam int W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ab_clk_i = 0, ba_clk_i = 0;
   logic ab_oe_i = 0, ba_oe_n_i = 1, ab_sel_i = 0, ba_sel_i = 0;
   logic [W-1:0] a_in_i = '0, b_in_i = '0;
   logic [W-1:0] a_out_o, b_out_o;
   logic a_oe_o, b_oe_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   regbus_xcvr #(.WIDTH(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .ab_clk_i(ab_clk_i), .ba_clk_i(ba_clk_i),
      .ab_oe_i(ab_oe_i), .ba_oe_n_i(ba_oe_n_i), .ab_sel_i(ab_sel_i),
      .ba_sel_i(ba_sel_i), .a_in_i(a_in_i), .a_out_o(a_out_o), .a_oe_o(a_oe_o),
      .b_in_i(b_in_i), .b_out_o(b_out_o), .b_oe_o(b_oe_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_ctl(input logic oe_ab, input logic oe_ba_n,
                          input logic s_ab, input logic s_ba);
      ab_oe_i = oe_ab; ba_oe_n_i = oe_ba_n; ab_sel_i = s_ab; ba_sel_i = s_ba;
   endtask

   task automatic cyc;
      @(negedge clk);
   endtask

   // raise chosen capture levels for one system cycle, then lower
   task automatic pulse(input logic pa, input logic pb);
      ab_clk_i = pa; ba_clk_i = pb;
      cyc();
      ab_clk_i = 0; ba_clk_i = 0;
      cyc();
   endtask

   // read both registers through the stored cross-drive mode (R6)
   task automatic read_regs(input string req, input int exp_a, input int exp_b);
      set_ctl(1, 0, 1, 1);
      #2;
      check({req, " A register"}, b_out_o, exp_a);
      check({req, " B register"}, a_out_o, exp_b);
      cyc();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int ka, kb;
      // R8: loop mode straight out of reset shows cleared hold values
      set_ctl(1, 0, 0, 0);
      a_in_i = 4'h7; b_in_i = 4'h9;
      repeat (3) cyc();
      rst_n = 1;
      cyc(); #2;
      check("R8 hold A after reset", a_out_o, 0);
      check("R8 hold B after reset", b_out_o, 0);
      cyc();
      read_regs("R8 reset", 0, 0);

      // R1: capture every value, in modes where the captured bus is undriven
      for (int v = 0; v < 16; v++) begin
         set_ctl(v[0], 1'b1, v[1], v[2]);
         a_in_i = v[W-1:0];
         b_in_i = v[W-1:0] ^ 4'hA;
         pulse(1, 0);
         set_ctl(1'b0, v[3], v[1], v[2]);
         pulse(0, 1);
         read_regs("R1 capture", v, v ^ 4'hA);
      end

      // R2/R3/R4: live routing sweep, A reg = 3, B reg = 12
      ka = 3; kb = 12;
      set_ctl(0, 1, 0, 0);
      a_in_i = 4'(ka); b_in_i = 4'(kb);
      pulse(1, 1);
      for (int m = 0; m < 16; m++) begin
         for (int va = 0; va < 16; va++) begin
            automatic logic oab = m[0], obn = m[1], sab = m[2], sba = m[3];
            automatic int vb = (va * 7 + 3) % 16;
            automatic int eb, ea;
            if (oab && !obn && !sab && !sba) continue;
            set_ctl(oab, obn, sab, sba);
            a_in_i = 4'(va); b_in_i = 4'(vb);
            #2;
            eb = !oab ? vb : (sab ? ka : (!obn ? kb : va));
            ea = obn ? va : (sba ? kb : (oab ? ka : vb));
            check("R2 B drive flag", b_oe_o, oab);
            check("R2 A drive flag", a_oe_o, !obn);
            if (oab)  check("R3 bus B value", b_out_o, eb);
            if (!obn) check("R3 bus A value", a_out_o, ea);
            cyc();
         end
      end

      // R7: store A in both registers
      set_ctl(1, 1, 0, 0);
      a_in_i = 4'h5; b_in_i = 4'hC;
      pulse(1, 1);
      read_regs("R7 A into both", 5, 5);
      // R7: store B in both registers
      set_ctl(0, 0, 0, 0);
      a_in_i = 4'h3; b_in_i = 4'hE;
      pulse(1, 1);
      read_regs("R7 B into both", 14, 14);

      // R4: capture from driven bus B (carries A reg) ignores B pads
      set_ctl(0, 1, 0, 0);
      a_in_i = 4'h6; pulse(1, 0);
      set_ctl(1, 1, 1, 0);
      b_in_i = 4'h1;
      pulse(0, 1);
      read_regs("R4 driven capture", 6, 6);

      // R6: exchange under simultaneous edges with both selects high
      set_ctl(0, 1, 0, 0);
      a_in_i = 4'h3; b_in_i = 4'h9;
      pulse(1, 1);
      set_ctl(1, 0, 1, 1);
      #2;
      check("R6 cross B carries A reg", b_out_o, 3);
      check("R6 cross A carries B reg", a_out_o, 9);
      pulse(1, 1);
      read_regs("R6 exchange", 9, 3);

      // R1: a level held high captures only once
      set_ctl(0, 1, 0, 0);
      a_in_i = 4'h2;
      ab_clk_i = 1; cyc();
      a_in_i = 4'hD; repeat (3) cyc();
      ab_clk_i = 0; cyc();
      read_regs("R1 held level", 2, 3);

      // R5: loop holds the previous cycle's bus values
      set_ctl(0, 1, 0, 0);
      a_in_i = 4'h6; b_in_i = 4'hB;
      cyc();
      set_ctl(1, 0, 0, 0);
      #2;
      check("R5 loop A held", a_out_o, 6);
      check("R5 loop B held", b_out_o, 11);
      for (int k = 0; k < 3; k++) begin
         a_in_i = 4'(k); b_in_i = 4'(k + 8);
         cyc(); #2;
         check("R5 loop A ignores pads", a_out_o, 6);
         check("R5 loop B ignores pads", b_out_o, 11);
      end
      pulse(1, 1);
      read_regs("R5 capture in loop", 6, 11);

      // R8: reset mid-run clears registers
      rst_n = 0; cyc(); rst_n = 1; cyc();
      read_regs("R8 mid-run reset", 0, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule